// File: doc/BRIEF.md
# Serial Transmitter with Enable-Sequenced Idle Preamble

This block serialises words from a one-entry holding buffer onto an asynchronous serial line. Each frame has a low start bit, eight or nine payload positions sent least significant bit first, and a high stop bit. When parity is on, the top payload position carries a parity bit instead of data. The line rests high, and every line change falls on a bit boundary. One bit time is a fixed number of baud ticks.

Transmission is gated by an enable input, and the edges of that input are sequenced:

- **Rising enable:** the first frame is preceded by one idle character, which is a whole character time of high line with no start or stop bit.
- **Enable dropped mid-frame:** the frame in flight finishes, and the line then stays quiet.
- **Enable dropped and raised again within a frame:** one idle character is queued behind that frame.
- **Enable raised during the stop bit:** the buffered word is discarded.

The transmitter owns the pin while it is enabled or still shifting. It releases the pin once it is disabled and quiet.

Top module: `uart_tx_preamble`

## Requirements
- R1: While reset is asserted and right after it, `txd` is 1, `tdre` is 1, `tc` is 1 and `pin_own` is 0.
- R2: With `nine_bit`=0 and `par_en`=0 a frame is 10 bit times: 0, then `wr_data[0]`..`wr_data[7]`, then 1. A word waiting in the buffer starts the bit time right after the previous frame's stop bit. A word written while the block is enabled and quiet starts at the next bit boundary.
- R3: With `par_en`=1 the top payload position carries parity instead of data. In 8-bit mode that is position 7, covering `wr_data[6:0]`. In 9-bit mode (`nine_bit`=1, frames of 11 bit times) it is position 8, covering `wr_data[7:0]`. The parity bit is the XOR of those bits when `par_odd`=0, and its inverse when `par_odd`=1. With `par_en`=0 and `nine_bit`=1, position 8 carries `wr_data[8]`.
- R4: A bit time is 16 `baud_tick` pulses. `txd` changes only on the clock edge that follows a cycle with `baud_tick` high.
- R5: After `tx_en` rises while no frame is shifting, the next bit boundary starts an idle character. The idle character is all ones and lasts 10 bit times (or 11 with `nine_bit`=1). Any buffered word follows right after it.
- R6: `tdre` goes to 0 on the cycle after `wr_stb` and returns to 1 when the word moves into the shifter. `tc` is 1 only when nothing is shifting, no idle character is queued and the buffer is empty.
- R7: If `tx_en` drops during a frame, that frame completes. After that, `txd` stays 1, `pin_own` is 0, and a word in the buffer is held unsent.
- R8: If `tx_en` drops and rises again before the stop bit of the current frame, one idle character of frame length is sent right after that frame, and the buffered word follows it.
- R9: If `tx_en` rises while the current frame's stop bit is on the line, the buffered word is discarded: `tdre` returns to 1 and that word is never sent.
- R10: `pin_own` is 1 whenever `tx_en` is 1 or a frame or idle character is shifting. `txd` is 1 whenever `pin_own` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, edge-sequenced |
| nine_bit | input | 1 | 1 selects nine payload positions (11-bit characters) |
| par_en | input | 1 | 1 puts parity in the top payload position |
| par_odd | input | 1 | 1 selects odd parity |
| wr_stb | input | 1 | Loads `wr_data` into the holding buffer |
| wr_data | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| baud_tick | input | 1 | Oversampling tick; 16 ticks make one bit time |
| txd | output | 1 | Serial line, high at rest |
| tdre | output | 1 | Holding buffer empty |
| tc | output | 1 | Transmission complete |
| pin_own | output | 1 | Transmitter drives the line |

## Verification
Each scenario starts from a quiet line and raises the enable. Checking the exact bit-time slot of the first start bit then separates a correct preamble from a missing or mis-sized one.

- **Two buffered words in a row:** shows that no gap is inserted between frames.
- **Enable drop, then a second word:** shows that the frame in flight completes but the waiting word is held.
- **Drop and re-raise mid-frame:** the following start shifts by exactly one character time.
- **Re-raise during the stop bit:** the buffered word disappears.
- **Words in 9-bit and 8-bit modes with even parity, odd parity and no parity:** these tell a parity slip from a data slip in the top position.

// File: rtl/uart_tx_preamble_pkg.sv
package uart_tx_preamble_pkg;

    localparam int FRAME_MAX = 11;
    localparam int LEN_W     = 4;
    localparam int WORD_W    = 9;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } txframe_t;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } txcfg_t;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_IDLE = 2'd1,
        LD_DATA = 2'd2
    } ldsel_e;

    function automatic logic [LEN_W-1:0] char_len(input logic nine);
        return nine ? LEN_W'(11) : LEN_W'(10);
    endfunction

    function automatic txframe_t idle_char(input logic nine);
        txframe_t f;
        f.bits = '1;
        f.len  = char_len(nine);
        return f;
    endfunction

    function automatic txframe_t data_char(input logic [WORD_W-1:0] d, input txcfg_t c);
        txframe_t          f;
        logic [WORD_W-1:0] body;
        logic              par;
        par  = (c.nine ? (^d[7:0]) : (^d[6:0])) ^ c.par_odd;
        body = d;
        if (c.par_en) begin
            if (c.nine) body[8] = par;
            else        body[7] = par;
        end
        f.bits = c.nine ? {1'b1, body[8:0], 1'b0} : {2'b11, body[7:0], 1'b0};
        f.len  = char_len(c.nine);
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_preamble_baud.sv
module uart_tx_preamble_baud #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic baud_tick,
    output logic bit_stb
);
    localparam int            CW   = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_stb = baud_tick && (cnt == LAST);
endmodule

// File: rtl/uart_tx_preamble_hold.sv
module uart_tx_preamble_hold
    import uart_tx_preamble_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    input  logic              drop,
    output logic              full,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (wr_stb) begin
            full <= 1'b1;
            word <= wr_data;
        end else if (take || drop) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_preamble_seq.sv
module uart_tx_preamble_seq
    import uart_tx_preamble_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tx_en,
    input  logic   bit_stb,
    input  logic   busy,
    input  logic   on_last,
    input  logic   buf_full,
    output ldsel_e ld,
    output logic   drop_buf,
    output logic   idle_pend
);
    logic en_q;
    logic rise;
    logic load_pt;

    assign rise    = tx_en & ~en_q;
    assign load_pt = bit_stb & (~busy | on_last);

    always_comb begin
        ld = LD_NONE;
        if (load_pt && tx_en) begin
            if (idle_pend || rise) ld = LD_IDLE;
            else if (buf_full)     ld = LD_DATA;
        end
    end

    // Re-enabling once the stop bit is already on the line loses the waiting word.
    assign drop_buf = rise & busy & on_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            idle_pend <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (load_pt)   idle_pend <= 1'b0;
            else if (rise) idle_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_preamble_shift.sv
module uart_tx_preamble_shift
    import uart_tx_preamble_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_stb,
    input  ldsel_e   ld,
    input  txframe_t frm,
    output logic     busy,
    output logic     on_last,
    output logic     line
);
    logic [FRAME_MAX-1:0] sh;
    logic [LEN_W-1:0]     left;

    assign busy    = (left != '0);
    assign on_last = (left == LEN_W'(1));
    assign line    = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
        end else if (ld != LD_NONE) begin
            sh   <= frm.bits;
            left <= frm.len;
        end else if (bit_stb && busy) begin
            sh   <= {1'b1, sh[FRAME_MAX-1:1]};
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_preamble.sv
module uart_tx_preamble
    import uart_tx_preamble_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       nine_bit,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       wr_stb,
    input  logic [8:0] wr_data,
    input  logic       baud_tick,
    output logic       txd,
    output logic       tdre,
    output logic       tc,
    output logic       pin_own
);
    logic              bit_stb;
    logic              busy;
    logic              on_last;
    logic              buf_full;
    logic [WORD_W-1:0] buf_word;
    logic              drop_buf;
    logic              idle_pend;
    ldsel_e            ld;
    txcfg_t            cfg;
    txframe_t          frm;

    assign cfg = '{nine: nine_bit, par_en: par_en, par_odd: par_odd};
    assign frm = (ld == LD_IDLE) ? idle_char(cfg.nine) : data_char(buf_word, cfg);

    uart_tx_preamble_baud #(.OSR(OSR)) baud_i (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .bit_stb   (bit_stb)
    );

    uart_tx_preamble_hold hold_i (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (ld == LD_DATA),
        .drop    (drop_buf),
        .full    (buf_full),
        .word    (buf_word)
    );

    uart_tx_preamble_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .bit_stb   (bit_stb),
        .busy      (busy),
        .on_last   (on_last),
        .buf_full  (buf_full),
        .ld        (ld),
        .drop_buf  (drop_buf),
        .idle_pend (idle_pend)
    );

    uart_tx_preamble_shift shift_i (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .ld      (ld),
        .frm     (frm),
        .busy    (busy),
        .on_last (on_last),
        .line    (txd)
    );

    assign tdre    = ~buf_full;
    assign tc      = ~busy & ~idle_pend & ~buf_full;
    assign pin_own = tx_en | busy;
endmodule

// File: rtl/uart_tx_preamble_chk.sv
module uart_tx_preamble_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic wr_stb,
    input logic baud_tick,
    input logic txd,
    input logic tdre,
    input logic tc,
    input logic pin_own
);
    AST_TXD_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(baud_tick));                                     // R4
    AST_HIGH_WHEN_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !pin_own |-> txd);                                                       // R10
    AST_OWN_WITH_ENABLE: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> pin_own);                                                      // R10
    AST_RELEASE_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && tc) |-> !pin_own);                                            // R7
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !tdre);                                                       // R6
    AST_TC_IMPLIES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tc |-> tdre);                                                            // R6
endmodule

bind uart_tx_preamble uart_tx_preamble_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .wr_stb    (wr_stb),
    .baud_tick (baud_tick),
    .txd       (txd),
    .tdre      (tdre),
    .tc        (tc),
    .pin_own   (pin_own)
);

// File: tb/uart_tx_preamble_tb_top.sv
module uart_tx_preamble_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       txd, tdre, tc, pin_own;

    int n_checks = 0;
    int n_fail   = 0;
    int slot     = 0;
    int btick    = 0;

    typedef struct {
        logic [10:0] vec;
        int          start;
        string       req;
    } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_preamble #(.OSR(OSR)) dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .nine_bit(nine_bit), .par_en(par_en),
        .par_odd(par_odd), .wr_stb(wr_stb), .wr_data(wr_data), .baud_tick(baud_tick),
        .txd(txd), .tdre(tdre), .tc(tc), .pin_own(pin_own)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected line bits, slot 0 first, built from the frame-format requirements.
    function automatic logic [10:0] model_vec(logic [8:0] d, bit nn, bit pe, bit po);
        int          nd = nn ? 9 : 8;
        logic [10:0] v  = '1;
        logic        p  = po;
        v[0] = 1'b0;
        for (int i = 0; i < nd - 1; i++) begin
            v[1+i] = d[i];
            p      = p ^ d[i];
        end
        v[nd]   = pe ? p : d[nd-1];
        v[nd+1] = 1'b1;
        return v;
    endfunction

    task automatic wait_slot(input int n);
        while (slot < n) @(negedge clk);
    endtask

    task automatic write_word(input logic [8:0] d);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic push(input logic [8:0] d, input int st, input string req);
        exp_t e;
        e.vec   = model_vec(d, nine_bit, par_en, par_odd);
        e.start = st;
        e.req   = req;
        expq.push_back(e);
    endtask

    initial begin : baud_gen
        forever begin
            @(negedge clk);
            baud_tick = rst ? 1'b0 : ~baud_tick;
        end
    end

    // Monitor: counts bit slots (16 ticks each) and decodes frames at slot starts.
    initial begin : monitor
        bit          in_fr;
        int          fs;
        int          nb;
        logic [10:0] got;
        exp_t        e;
        in_fr = 1'b0; fs = 0; nb = 0; got = '1;
        forever begin
            @(posedge clk);
            if (rst) begin
                btick = 0;
                slot  = 0;
            end else if (baud_tick) begin
                if (btick == OSR - 1) begin
                    btick = 0;
                    slot++;
                    @(negedge clk);
                    if (!in_fr) begin
                        if (txd == 1'b0) begin
                            in_fr = 1'b1; fs = slot; nb = 1; got = '1; got[0] = 1'b0;
                        end
                    end else begin
                        got[nb] = txd;
                        nb++;
                        if (nb == (nine_bit ? 11 : 10)) begin
                            in_fr = 1'b0;
                            if (expq.size() == 0) begin
                                chk(1'b0, "R2 unexpected frame on line", int'(got), 0);
                            end else begin
                                e = expq.pop_front();
                                chk(got == e.vec, {e.req, " frame bits"}, int'(got), int'(e.vec));
                                chk(fs == e.start, {e.req, " start slot (R4 bit time)"}, fs, e.start);
                            end
                        end
                    end
                end else begin
                    btick++;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", slot, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stimulus
        int k, as, bs, ds, s1;
        repeat (4) @(negedge clk);
        chk(txd === 1'b1,     "R1 txd in reset", txd, 1);
        chk(tdre === 1'b1,    "R1 tdre in reset", tdre, 1);
        chk(tc === 1'b1,      "R1 tc in reset", tc, 1);
        chk(pin_own === 1'b0, "R1 pin_own in reset", pin_own, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1 && tdre === 1'b1 && tc === 1'b1 && pin_own === 1'b0,
            "R1 state after reset", {txd, tdre, tc, pin_own}, 4'b1110);

        // Preamble, then two back-to-back frames (R5, R2, R6)
        wait_slot(2);
        write_word(9'h05A);
        chk(tdre === 1'b0, "R6 tdre clears after write", tdre, 0);
        k = slot;
        push(9'h05A, k + 11, "R5 preamble before first frame");
        tx_en = 1'b1;
        @(negedge clk);
        chk(pin_own === 1'b1, "R10 owned while enabled", pin_own, 1);
        wait_slot(k + 5);
        chk(txd === 1'b1, "R5 idle character is high", txd, 1);
        wait_slot(k + 10);
        chk(tdre === 1'b0, "R6 word waits during preamble", tdre, 0);
        chk(tc === 1'b0, "R6 tc low while busy", tc, 0);
        wait_slot(k + 11);
        chk(tdre === 1'b1, "R6 tdre sets on load", tdre, 1);
        write_word(9'h0C3);
        push(9'h0C3, k + 21, "R2 back-to-back frame");
        wait_slot(k + 30);
        chk(tc === 1'b0, "R6 tc low during last frame", tc, 0);
        wait_slot(k + 31);
        chk(tc === 1'b1 && tdre === 1'b1, "R6 tc after all sent", tc, 1);
        tx_en = 1'b0;
        @(negedge clk);
        chk(pin_own === 1'b0, "R7 pin released when disabled and quiet", pin_own, 0);

        // Enable dropped mid-frame (R7)
        wait_slot(slot + 2);
        k = slot;
        write_word(9'h0E7);
        as = k + 11;
        push(9'h0E7, as, "R7 frame finishes after enable drop");
        tx_en = 1'b1;
        wait_slot(as + 3);
        tx_en = 1'b0;
        write_word(9'h03D);
        wait_slot(as + 10);
        chk(pin_own === 1'b0, "R7 released after frame end", pin_own, 0);
        chk(txd === 1'b1, "R7 line high after frame end", txd, 1);
        wait_slot(as + 25);
        chk(tdre === 1'b0, "R7 buffered word held unsent", tdre, 0);
        chk(txd === 1'b1, "R7 line stays idle", txd, 1);

        // Re-enable sends preamble then held word; toggle queues idle (R5, R8)
        k = slot;
        bs = k + 11;
        push(9'h03D, bs, "R5 preamble then held word");
        tx_en = 1'b1;
        wait_slot(bs);
        write_word(9'h081);
        push(9'h081, bs + 20, "R8 queued idle before next word");
        wait_slot(bs + 4);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        wait_slot(bs + 15);
        chk(txd === 1'b1 && pin_own === 1'b1, "R8 queued idle keeps line high", txd, 1);
        chk(tdre === 1'b0, "R8 word waits behind idle", tdre, 0);
        wait_slot(bs + 31);
        chk(tc === 1'b1, "R8 complete after idle and word", tc, 1);
        tx_en = 1'b0;

        // Re-enable during stop bit drops the buffered word (R9)
        wait_slot(slot + 2);
        k = slot;
        write_word(9'h0A6);
        ds = k + 11;
        push(9'h0A6, ds, "R5 preamble before frame");
        tx_en = 1'b1;
        wait_slot(ds);
        write_word(9'h0FF);
        wait_slot(ds + 2);
        tx_en = 1'b0;
        wait_slot(ds + 9);
        tx_en = 1'b1;
        @(negedge clk);
        chk(tdre === 1'b1, "R9 buffered word discarded", tdre, 1);
        wait_slot(ds + 20);
        chk(tc === 1'b1, "R9 nothing left after idle", tc, 1);
        k = slot;
        write_word(9'h012);
        push(9'h012, k + 1, "R2 start at next boundary when enabled");
        wait_slot(k + 12);
        chk(tc === 1'b1, "R2 single frame done", tc, 1);
        tx_en = 1'b0;

        // Nine-bit frames and parity (R3)
        nine_bit = 1'b1; par_en = 1'b1; par_odd = 1'b0;
        wait_slot(slot + 2);
        k = slot;
        write_word(9'h0B5);
        s1 = k + 12;
        push(9'h0B5, s1, "R3 nine-bit even parity");
        tx_en = 1'b1;
        wait_slot(s1);
        par_odd = 1'b1;
        write_word(9'h03C);
        push(9'h03C, s1 + 11, "R3 nine-bit odd parity");
        wait_slot(s1 + 11);
        par_en = 1'b0;
        write_word(9'h1A5);
        push(9'h1A5, s1 + 22, "R3 nine-bit data in top position");
        wait_slot(s1 + 34);
        chk(tc === 1'b1, "R3 nine-bit sequence done", tc, 1);
        tx_en = 1'b0;

        // Eight-bit with parity
        wait_slot(slot + 2);
        nine_bit = 1'b0; par_en = 1'b1; par_odd = 1'b0;
        k = slot;
        write_word(9'h04F);
        push(9'h04F, k + 11, "R3 eight-bit even parity");
        tx_en = 1'b1;
        wait_slot(k + 22);
        chk(tc === 1'b1, "R3 eight-bit parity frame done", tc, 1);
        tx_en = 1'b0;

        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R2 all expected frames seen", expq.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule